// File: doc/BRIEF.md
# Register-Mapped Multi-Function I/O Port

This block multiplexes an eight-bit general-purpose I/O port onto a set of internal status and control bits. Each pin has its own small configuration register. That register holds a direction flag and a five-bit function selector. An output pin carries a read-only status bit out of the chip. An input pin drives a writable control bit from the board. The status sources are plain inputs here.

A host programs the registers over a ten-bit multiplexed address/data bus. The host strobes the address on one clock edge and the data word on the next. The block refuses any write that pairs a function with the wrong direction, and records the refusal in a sticky error flag. After reset, the lock indication and the self-test pass flag are already routed to fixed pins.

Top module: `iop_mux_port`

## Requirements
- R1: After reset:
  - pin 4 is an output carrying status bit 2 (lock, register value 0x002).
  - pin 6 is an output carrying status bit 3 (self-test pass, 1 on pass, value 0x003).
  - pin 7 is an input feeding control bit 0 (value 0x030).
  - every other pin is an output on unassigned code 31 (value 0x01F).
  - the error flag is 0, the control bits are 0 and the read data is 0.
- R2: A write takes two strobes with select low and write-enable low. The first strobe captures the address and the second captures the data. Pin p's register sits at address 0x00F + p, so the registers occupy 0x00F to 0x016. The new setting shows on the pins two clock edges after the data strobe.
- R3: Data bit 5 selects direction: 1 makes the pin an input (pin_oe low, pin_out 0), and 0 makes it an output (pin_oe high).
- R4: Data bits 4:0 select the function. Codes 0 to 7 are status bits 0 to 7, and these are output-only. Codes 16 to 23 are control bits 0 to 7, and these are input-only.
- R5: A write of a status code with bit 5 set, or a control code with bit 5 clear, leaves the register unchanged and sets cfg_err. cfg_err stays set until reset.
- R6: Codes with no function are legal in both directions. An output pin on such a code drives 0, and an input pin on such a code changes no control bit.
- R7: A read uses two strobes with select low and write-enable high. The read data updates on the second strobe edge to {4'b0, dir, code}. Data bits 9:6 of a write are dropped, and an address outside the register range reads 0.
- R8: Each control bit follows the lowest-numbered input pin mapped to it, one edge after sampling. A control bit with no input pin mapped to it holds its value.
- R9: A strobe with select high is ignored, and it returns the bus to the address step.
- R10: A write to an address outside the register range changes no register and does not set cfg_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_stb | input | 1 | Bus strobe, one step per sampled edge |
| host_sel_n | input | 1 | Low selects the configuration registers |
| host_wr_n | input | 1 | Low for write, high for read |
| host_ad | input | 10 | Multiplexed address/data |
| host_rdata | output | 10 | Registered read data |
| cfg_err | output | 1 | Sticky refused-direction flag |
| status_i | input | 8 | Internal status bits |
| pin_in | input | 8 | Port pin input levels |
| pin_out | output | 8 | Port pin output levels |
| pin_oe | output | 8 | Port pin output enables |
| ctrl_o | output | 8 | Control bits driven from pins |

## Verification
The checks assume that reset is held for at least two clock cycles, because the pin enables settle one edge after the registers reload. They also assume the bus stays idle with the strobe low from time zero. The assertion that pin enables change only after a write depends on status and pin levels never altering direction, and that holds by the block's definition. The stimulus keeps reset high for three cycles and moves every bus signal on falling edges. It also leaves the strobe low between transactions, so the address step is always known.

// File: rtl/iop_pkg.sv
package iop_pkg;
  localparam int CODE_W = 5;
  localparam int CFG_W  = CODE_W + 1;
  localparam logic [CODE_W-1:0] CODE_NONE = '1;

  typedef struct packed {
    logic              dir;   // 1 = input
    logic [CODE_W-1:0] code;
  } pin_cfg_t;

  function automatic pin_cfg_t dflt_cfg(int p, int last, int lock_pin, int pass_pin,
                                        int lock_idx, int pass_idx, int ctrl_base);
    pin_cfg_t c;
    c.dir  = 1'b0;
    c.code = CODE_NONE;
    if (p == lock_pin)      c.code = CODE_W'(lock_idx);
    else if (p == pass_pin) c.code = CODE_W'(pass_idx);
    else if (p == last) begin
      c.dir  = 1'b1;
      c.code = CODE_W'(ctrl_base);
    end
    return c;
  endfunction

  function automatic logic bad_dir(pin_cfg_t c, int stat_n, int ctrl_base, int ctrl_n);
    logic is_stat;
    logic is_ctrl;
    is_stat = int'(c.code) < stat_n;
    is_ctrl = (int'(c.code) >= ctrl_base) && (int'(c.code) < ctrl_base + ctrl_n);
    return (is_stat && c.dir) || (is_ctrl && !c.dir);
  endfunction
endpackage

// File: rtl/iop_host_if.sv
module iop_host_if #(
  parameter int AD_W = 10,
  parameter int PINS = 8,
  parameter logic [AD_W-1:0] BASE = 'h00F
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    stb,
  input  logic                    sel_n,
  input  logic                    wr_n,
  input  logic [AD_W-1:0]         ad,
  output logic                    wr_go,
  output logic                    rd_go,
  output logic                    hit,
  output logic [$clog2(PINS)-1:0] idx
);
  localparam int IDX_W = $clog2(PINS);

  logic            phase_q;   // 0 = address step, 1 = data step
  logic [AD_W-1:0] addr_q;
  logic [AD_W-1:0] off;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      addr_q  <= '0;
    end else if (stb) begin
      if (sel_n) begin
        phase_q <= 1'b0;
      end else begin
        phase_q <= ~phase_q;
        if (!phase_q) addr_q <= ad;
      end
    end
  end

  assign off   = addr_q - BASE;
  assign hit   = (addr_q >= BASE) && (off < AD_W'(PINS));
  assign idx   = off[IDX_W-1:0];
  assign wr_go = stb && !sel_n && phase_q && !wr_n;
  assign rd_go = stb && !sel_n && phase_q && wr_n;
endmodule

// File: rtl/iop_cfg_file.sv
module iop_cfg_file
  import iop_pkg::*;
#(
  parameter int AD_W      = 10,
  parameter int PINS      = 8,
  parameter int STAT_N    = 8,
  parameter int CTRL_N    = 8,
  parameter int CTRL_BASE = 16,
  parameter int LOCK_PIN  = 4,
  parameter int PASS_PIN  = 6,
  parameter int LOCK_IDX  = 2,
  parameter int PASS_IDX  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_go,
  input  logic                     rd_go,
  input  logic                     hit,
  input  logic [$clog2(PINS)-1:0]  idx,
  input  logic [CFG_W-1:0]         wdata,
  output logic [AD_W-1:0]          rdata,
  output logic                     err,
  output logic [PINS-1:0]          dir_o,
  output logic [PINS*CODE_W-1:0]   code_o
);
  pin_cfg_t cfg_q [PINS];
  pin_cfg_t wcfg;
  logic     refuse;

  assign wcfg   = pin_cfg_t'(wdata);
  assign refuse = bad_dir(wcfg, STAT_N, CTRL_BASE, CTRL_N);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < PINS; p++)
        cfg_q[p] <= dflt_cfg(p, PINS - 1, LOCK_PIN, PASS_PIN, LOCK_IDX, PASS_IDX, CTRL_BASE);
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      if (wr_go && hit) begin
        if (refuse) err <= 1'b1;
        else        cfg_q[idx] <= wcfg;
      end
      if (rd_go) rdata <= hit ? AD_W'(cfg_q[idx]) : '0;
    end
  end

  for (genvar p = 0; p < PINS; p++) begin : g_out
    assign dir_o[p]                   = cfg_q[p].dir;
    assign code_o[p*CODE_W +: CODE_W] = cfg_q[p].code;
  end
endmodule

// File: rtl/iop_pin_route.sv
module iop_pin_route
  import iop_pkg::*;
#(
  parameter int PINS      = 8,
  parameter int STAT_N    = 8,
  parameter int CTRL_N    = 8,
  parameter int CTRL_BASE = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PINS-1:0]        dir_i,
  input  logic [PINS*CODE_W-1:0] code_i,
  input  logic [STAT_N-1:0]      status_i,
  input  logic [PINS-1:0]        pin_in,
  output logic [PINS-1:0]        pin_out,
  output logic [PINS-1:0]        pin_oe,
  output logic [CTRL_N-1:0]      ctrl_o
);
  logic [PINS-1:0]   out_d;
  logic [CTRL_N-1:0] ctrl_d;

  always_comb begin
    out_d = '0;
    for (int p = 0; p < PINS; p++)
      for (int s = 0; s < STAT_N; s++)
        if (!dir_i[p] && code_i[p*CODE_W +: CODE_W] == CODE_W'(s))
          out_d[p] = status_i[s];
    ctrl_d = ctrl_o;
    // descending scan: the lowest-numbered pin is written last and wins
    for (int p = PINS - 1; p >= 0; p--)
      for (int k = 0; k < CTRL_N; k++)
        if (dir_i[p] && code_i[p*CODE_W +: CODE_W] == CODE_W'(CTRL_BASE + k))
          ctrl_d[k] = pin_in[p];
  end

  always_ff @(posedge clk) begin
    pin_oe <= ~dir_i;   // follows the configuration, which is itself reset
    if (rst) begin
      pin_out <= '0;
      ctrl_o  <= '0;
    end else begin
      pin_out <= out_d;
      ctrl_o  <= ctrl_d;
    end
  end
endmodule

// File: rtl/iop_mux_port.sv
module iop_mux_port
  import iop_pkg::*;
#(
  parameter int AD_W      = 10,
  parameter int PINS      = 8,
  parameter int STAT_N    = 8,
  parameter int CTRL_N    = 8,
  parameter int CTRL_BASE = 16,
  parameter logic [AD_W-1:0] BASE = 'h00F,
  parameter int LOCK_PIN  = 4,
  parameter int PASS_PIN  = 6,
  parameter int LOCK_IDX  = 2,
  parameter int PASS_IDX  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_stb,
  input  logic              host_sel_n,
  input  logic              host_wr_n,
  input  logic [AD_W-1:0]   host_ad,
  output logic [AD_W-1:0]   host_rdata,
  output logic              cfg_err,
  input  logic [STAT_N-1:0] status_i,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [CTRL_N-1:0] ctrl_o
);
  localparam int IDX_W = $clog2(PINS);

  logic                   wr_go, rd_go, hit;
  logic [IDX_W-1:0]       idx;
  logic [PINS-1:0]        dir_w;
  logic [PINS*CODE_W-1:0] code_w;

  iop_host_if #(.AD_W(AD_W), .PINS(PINS), .BASE(BASE)) host_i (
    .clk(clk), .rst(rst), .stb(host_stb), .sel_n(host_sel_n), .wr_n(host_wr_n),
    .ad(host_ad), .wr_go(wr_go), .rd_go(rd_go), .hit(hit), .idx(idx)
  );

  iop_cfg_file #(
    .AD_W(AD_W), .PINS(PINS), .STAT_N(STAT_N), .CTRL_N(CTRL_N), .CTRL_BASE(CTRL_BASE),
    .LOCK_PIN(LOCK_PIN), .PASS_PIN(PASS_PIN), .LOCK_IDX(LOCK_IDX), .PASS_IDX(PASS_IDX)
  ) cfg_i (
    .clk(clk), .rst(rst), .wr_go(wr_go), .rd_go(rd_go), .hit(hit), .idx(idx),
    .wdata(host_ad[CFG_W-1:0]), .rdata(host_rdata), .err(cfg_err),
    .dir_o(dir_w), .code_o(code_w)
  );

  iop_pin_route #(
    .PINS(PINS), .STAT_N(STAT_N), .CTRL_N(CTRL_N), .CTRL_BASE(CTRL_BASE)
  ) route_i (
    .clk(clk), .rst(rst), .dir_i(dir_w), .code_i(code_w), .status_i(status_i),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .ctrl_o(ctrl_o)
  );
endmodule

// File: rtl/iop_mux_port_chk.sv
module iop_mux_port_chk #(
  parameter int AD_W   = 10,
  parameter int PINS   = 8,
  parameter int CTRL_N = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              host_stb,
  input logic              host_sel_n,
  input logic              host_wr_n,
  input logic [AD_W-1:0]   host_rdata,
  input logic              cfg_err,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe,
  input logic [CTRL_N-1:0] ctrl_o
);
  localparam logic [PINS-1:0] OE_DEF = {1'b0, {(PINS-1){1'b1}}};

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == OE_DEF && pin_out == '0 && ctrl_o == '0 && !cfg_err));

  assert_oe_after_write_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(pin_oe) |-> $past(host_stb && !host_sel_n && !host_wr_n, 2));

  assert_input_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == '0);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  assert_err_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_err) |-> $past(host_stb && !host_sel_n && !host_wr_n));

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !host_stb |=> $stable(host_rdata));
endmodule

bind iop_mux_port iop_mux_port_chk #(.AD_W(AD_W), .PINS(PINS), .CTRL_N(CTRL_N)) chk_i (
  .clk(clk), .rst(rst), .host_stb(host_stb), .host_sel_n(host_sel_n),
  .host_wr_n(host_wr_n), .host_rdata(host_rdata), .cfg_err(cfg_err),
  .pin_out(pin_out), .pin_oe(pin_oe), .ctrl_o(ctrl_o)
);

// File: tb/iop_mux_port_tb_top.sv
module iop_mux_port_tb_top;
  localparam int PINS = 8;
  localparam int STAT_N = 8;
  localparam int CTRL_N = 8;
  localparam int CTRL_BASE = 16;
  localparam int BASE = 15;
  localparam int NVEC = 11;

  // {address, data, status_i, pin_in}
  localparam logic [35:0] VECS [NVEC] = '{
    {10'h00F, 10'h005, 8'hA5, 8'h00},  // R4 pin0 -> status5
    {10'h010, 10'h030, 8'hA5, 8'h02},  // R8 pin1 input ctrl0
    {10'h011, 10'h025, 8'hA5, 8'h02},  // R5 status code as input
    {10'h012, 10'h011, 8'h5A, 8'h02},  // R5 control code as output
    {10'h013, 10'h01E, 8'hFF, 8'h02},  // R6 pin4 output unassigned
    {10'h014, 10'h03C, 8'hFF, 8'h22},  // R6 pin5 input unassigned
    {10'h017, 10'h000, 8'h3C, 8'h22},  // R10 out of range
    {10'h015, 10'h3C7, 8'h80, 8'h00},  // R7 pin6 upper bits dropped
    {10'h016, 10'h035, 8'h80, 8'h80},  // R8 pin7 input ctrl5
    {10'h00F, 10'h031, 8'h81, 8'h81},  // R3 pin0 input ctrl1
    {10'h010, 10'h01F, 8'h81, 8'hFE}   // R8 ctrl0 unmapped, holds
  };

  logic clk = 1'b0, rst = 1'b1;
  logic host_stb = 1'b0, host_sel_n = 1'b1, host_wr_n = 1'b1;
  logic [9:0] host_ad = '0;
  logic [9:0] host_rdata;
  logic cfg_err;
  logic [7:0] status_i = 8'h0C, pin_in = 8'h00;
  logic [7:0] pin_out, pin_oe, ctrl_o;

  int n_cmp = 0, n_bad = 0;
  logic       m_dir [PINS];
  logic [4:0] m_code [PINS];
  logic [7:0] m_ctrl = '0;
  logic       m_err = 1'b0;

  always #4 clk = ~clk;

  iop_mux_port dut_i (
    .clk(clk), .rst(rst), .host_stb(host_stb), .host_sel_n(host_sel_n),
    .host_wr_n(host_wr_n), .host_ad(host_ad), .host_rdata(host_rdata), .cfg_err(cfg_err),
    .status_i(status_i), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .ctrl_o(ctrl_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit m_refused(logic d, logic [4:0] c);
    return (int'(c) < STAT_N && d) ||
           (int'(c) >= CTRL_BASE && int'(c) < CTRL_BASE + CTRL_N && !d);
  endfunction

  task automatic m_write(logic [9:0] a, logic [9:0] d);
    int i = int'(a) - BASE;
    if (i >= 0 && i < PINS) begin
      if (m_refused(d[5], d[4:0])) m_err = 1'b1;
      else begin
        m_dir[i]  = d[5];
        m_code[i] = d[4:0];
      end
    end
  endtask

  task automatic m_ctrl_step();
    for (int k = 0; k < CTRL_N; k++)
      for (int p = PINS - 1; p >= 0; p--)
        if (m_dir[p] && int'(m_code[p]) == CTRL_BASE + k) m_ctrl[k] = pin_in[p];
  endtask

  task automatic check_pins(string tag);
    logic [7:0] e_oe, e_out;
    for (int p = 0; p < PINS; p++) begin
      e_oe[p]  = !m_dir[p];
      e_out[p] = (!m_dir[p] && int'(m_code[p]) < STAT_N) ? status_i[m_code[p][2:0]] : 1'b0;
    end
    chk(tag, "pin_oe", 32'(pin_oe), 32'(e_oe));
    chk(tag, "pin_out", 32'(pin_out), 32'(e_out));
    chk(tag, "ctrl_o", 32'(ctrl_o), 32'(m_ctrl));
    chk(tag, "cfg_err", 32'(cfg_err), 32'(m_err));
  endtask

  task automatic bus(logic [9:0] a, logic [9:0] d, logic wr_n);
    @(negedge clk);
    host_stb = 1'b1; host_sel_n = 1'b0; host_wr_n = wr_n; host_ad = a;
    @(negedge clk);
    host_ad = d;
    @(negedge clk);
    host_stb = 1'b0; host_sel_n = 1'b1; host_wr_n = 1'b1; host_ad = '0;
  endtask

  task automatic read_chk(string tag, logic [9:0] a, logic [9:0] exp);
    bus(a, 10'h000, 1'b1);
    chk(tag, "host_rdata", 32'(host_rdata), 32'(exp));
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
    m_ctrl_step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R2 watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < PINS; p++) begin
      m_dir[p] = 1'b0; m_code[p] = 5'h1F;
    end
    m_code[4] = 5'd2; m_code[6] = 5'd3;
    m_dir[7] = 1'b1; m_code[7] = 5'd16;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1 reset state: lock (status2) on pin4, pass (status3) on pin6
    chk("R1", "pin_out", 32'(pin_out), 32'h50);
    chk("R1", "host_rdata", 32'(host_rdata), 32'h0);
    check_pins("R1");
    read_chk("R1", 10'h016, 10'h030);
    read_chk("R1", 10'h013, 10'h002);
    read_chk("R1", 10'h015, 10'h003);
    read_chk("R1", 10'h00F, 10'h01F);

    for (int v = 0; v < NVEC; v++) begin
      bus(VECS[v][35:26], VECS[v][25:16], 1'b0);
      m_write(VECS[v][35:26], VECS[v][25:16]);
      status_i = VECS[v][15:8];
      pin_in   = VECS[v][7:0];
      settle();
      check_pins("R2");
    end

    read_chk("R7", 10'h015, 10'h007);
    read_chk("R5", 10'h011, 10'h01F);
    read_chk("R5", 10'h012, 10'h01F);
    read_chk("R6", 10'h014, 10'h03C);
    read_chk("R10", 10'h020, 10'h000);
    read_chk("R3", 10'h00F, 10'h031);

    // R9: a deselected strobe between address and data restarts the sequence
    @(negedge clk);
    host_stb = 1'b1; host_sel_n = 1'b0; host_wr_n = 1'b0; host_ad = 10'h00F;
    @(negedge clk);
    host_sel_n = 1'b1;
    @(negedge clk);
    host_sel_n = 1'b0; host_ad = 10'h00F;
    @(negedge clk);
    host_ad = 10'h000;
    @(negedge clk);
    host_stb = 1'b0; host_sel_n = 1'b1; host_wr_n = 1'b1; host_ad = '0;
    m_write(10'h00F, 10'h000);
    status_i = 8'h01;
    settle();
    check_pins("R9");
    read_chk("R9", 10'h00F, 10'h000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule